// File: doc/BRIEF.md
# Convolution Mask Unique-Tap Analyzer

This block reads a 3x3 convolution mask of signed coefficients. It finds how many different coefficient values the mask holds. For each different value it builds an entry: the value itself and a 9-bit position mask that marks every tap carrying that value. A convolver can use these entries to add the pixels that share a coefficient before it multiplies. Fewer distinct values need fewer multiplies per pixel, so the block also reports how many pixels the convolver can handle in parallel with a fixed budget of multipliers.

The analysis is sequential. A load strobe captures the mask into an internal register. A small controller then visits one tap per cycle in row-major order. Each tap is compared against every entry found so far. On a hit, the tap's position bit is set in the matching entry. On a miss, a new entry is appended. After the ninth tap, `done` rises, and the tables hold still until the next accepted load.

Top module: `mask_tap_analyzer`

## Requirements
- R1: A load strobe sampled high at clock edge k while the block is not analysing is accepted. `busy` is high after edge k and stays high through edge k+8. `done` goes high after edge k+9. `busy` and `done` are never high together.
- R2: After `done`, `distinct_cnt` equals the number of different signed values among the nine taps, from 1 to 9. Four fixed cases must hold: an all-equal smoothing mask gives 1; eight -1 taps with a centre of 8 give 2; the horizontal-gradient mask with rows (-1,-1,-1), (0,0,0), (1,1,1) gives 3; the mask with rows (-1,-2,-1), (0,0,0), (1,2,1) gives 5.
- R3: Tap i sits in bits [8i+7:8i] of `mask_in`, where i = 3*row + column (row-major scan order). Entry j sits in bits [8j+7:8j] of `group_val` and bits [9j+8:9j] of `group_mem`. Entries are numbered in order of first appearance in the scan, so entry j holds the value of the j-th new value met.
- R4: After `done`, bit i of entry j's position mask is 1 exactly when tap i equals entry j's value. Because of this, the masks of the valid entries are disjoint and OR together to 9'h1FF. Entries at index `distinct_cnt` and above read zero value and zero mask.
- R5: `pix_par` is 18 for 1 distinct value, 9 for 2, 6 for 3, 4 for 4, 3 for 5 or 6, 2 for 7 to 9, and 0 when `distinct_cnt` is 0.
- R6: A load strobe that arrives while `busy` is high is ignored. The running analysis neither restarts nor changes timing. Its result still reflects the mask captured at the accepted load, even if `mask_in` has changed since.
- R7: From `done` until the next accepted load, `done` stays high and `distinct_cnt`, `group_val`, `group_mem` and `pix_par` do not change, whatever `mask_in` does.
- R8: After synchronous reset, `busy`, `done`, `distinct_cnt`, `pix_par` and all entry fields are zero.
- R9: A load strobe while `done` is high is accepted. After that edge, `done` is low and `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start strobe; captures `mask_in` when not busy |
| mask_in | input | 72 | Nine signed 8-bit taps, row-major, tap 0 in the low byte |
| busy | output | 1 | Analysis in progress |
| done | output | 1 | Tables valid and held |
| distinct_cnt | output | 4 | Number of distinct coefficient values |
| group_val | output | 72 | Coefficient value of each entry, entry 0 in the low byte |
| group_mem | output | 81 | 9-bit tap position mask of each entry, entry 0 in the low bits |
| pix_par | output | 5 | Pixels the convolver may process per pass |

## Verification
Some properties are checked on every cycle:
- The controller steps through all nine taps in order, one per cycle, with no gap and no restart.
- At most one entry ever matches the current tap.
- When `done` is high, the count lies between 1 and 9, the position masks cover exactly nine bits and OR to all ones, and the parallelism level is the largest that fits the multiplier budget.
- While no load arrives, the result stays frozen.

Other behaviour only the bench scenarios can show: first-appearance numbering of the entries, the exact value in each entry, the known filter cases, that an ignored strobe keeps the first mask's result, and that a changing `mask_in` cannot reach the held tables.

// File: rtl/tap_an_pkg.sv
package tap_an_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_e;

    // Pixels per pass for a given number of distinct values and multiplier budget.
    function automatic int unsigned pass_pixels(input int unsigned budget,
                                                input int unsigned n_distinct);
        if (n_distinct == 0)
            return 0;
        return budget / n_distinct;
    endfunction

endpackage

// File: rtl/tap_scan_ctrl.sv
module tap_scan_ctrl
    import tap_an_pkg::*;
#(
    parameter int N_TAPS = 9,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    output logic             start_o,
    output logic             step_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_TAPS - 1);

    scan_state_e      state_q;
    logic [IDX_W-1:0] idx_q;

    assign start_o = load_i && (state_q != ST_SCAN);
    assign step_o  = (state_q == ST_SCAN);
    assign idx_o   = idx_q;
    assign busy_o  = (state_q == ST_SCAN);
    assign done_o  = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else if (start_o) begin
            state_q <= ST_SCAN;
            idx_q   <= '0;
        end else if (state_q == ST_SCAN) begin
            if (idx_q == LAST_IDX) begin
                state_q <= ST_DONE;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    AST_SCAN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && idx_q != LAST_IDX) |=> (state_q == ST_SCAN && idx_q == $past(idx_q) + 1'b1)); // R6

    AST_SCAN_ENDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && idx_q == LAST_IDX) |=> done_o); // R1

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({busy_o, done_o})); // R1

    AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (done_o && load_i) |=> (busy_o && idx_q == '0)); // R9

endmodule

// File: rtl/tap_match_unit.sv
module tap_match_unit #(
    parameter int N_TAPS = 9,
    parameter int COEF_W = 8,
    parameter int CNT_W  = 4,
    parameter int IDX_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [COEF_W-1:0]        tap_i,
    input  logic [N_TAPS*COEF_W-1:0] tbl_val_i,
    input  logic [CNT_W-1:0]         count_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         slot_o
);
    logic [N_TAPS-1:0] eq;

    for (genvar j = 0; j < N_TAPS; j++) begin : g_cmp
        assign eq[j] = (CNT_W'(j) < count_i) &&
                       (tbl_val_i[j*COEF_W +: COEF_W] == tap_i);
    end

    always_comb begin
        hit_o  = 1'b0;
        slot_o = '0;
        for (int j = 0; j < N_TAPS; j++) begin
            if (eq[j] && !hit_o) begin
                hit_o  = 1'b1;
                slot_o = IDX_W'(j);
            end
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eq)); // R2

endmodule

// File: rtl/tap_group_table.sv
module tap_group_table #(
    parameter int N_TAPS = 9,
    parameter int COEF_W = 8,
    parameter int CNT_W  = 4,
    parameter int IDX_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     step_i,
    input  logic                     done_i,
    input  logic [IDX_W-1:0]         idx_i,
    input  logic [COEF_W-1:0]        tap_i,
    input  logic                     hit_i,
    input  logic [IDX_W-1:0]         slot_i,
    output logic [N_TAPS*COEF_W-1:0] val_o,
    output logic [N_TAPS*N_TAPS-1:0] mem_o,
    output logic [CNT_W-1:0]         count_o
);
    logic [COEF_W-1:0] val_q [N_TAPS];
    logic [N_TAPS-1:0] mem_q [N_TAPS];
    logic [CNT_W-1:0]  count_q;

    always_ff @(posedge clk) begin
        if (rst || start_i) begin
            count_q <= '0;
            for (int j = 0; j < N_TAPS; j++) begin
                val_q[j] <= '0;
                mem_q[j] <= '0;
            end
        end else if (step_i) begin
            if (hit_i) begin
                mem_q[slot_i][idx_i] <= 1'b1;
            end else begin
                val_q[count_q] <= tap_i;
                mem_q[count_q] <= N_TAPS'(1) << idx_i;
                count_q        <= count_q + 1'b1;
            end
        end
    end

    for (genvar j = 0; j < N_TAPS; j++) begin : g_pack
        assign val_o[j*COEF_W +: COEF_W] = val_q[j];
        assign mem_o[j*N_TAPS +: N_TAPS] = mem_q[j];
    end
    assign count_o = count_q;

    // Checker-side view of the finished table
    logic [N_TAPS-1:0] cover_or;
    int unsigned       cover_sum;
    always_comb begin
        cover_or  = '0;
        cover_sum = 0;
        for (int j = 0; j < N_TAPS; j++) begin
            cover_or  = cover_or | mem_q[j];
            cover_sum = cover_sum + int'($countones(mem_q[j]));
        end
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        done_i |-> (count_q >= CNT_W'(1) && count_q <= CNT_W'(N_TAPS))); // R2

    AST_MASK_PARTITION: assert property (@(posedge clk) disable iff (rst)
        done_i |-> (cover_or == {N_TAPS{1'b1}} && cover_sum == N_TAPS)); // R4

endmodule

// File: rtl/tap_par_select.sv
module tap_par_select
    import tap_an_pkg::*;
#(
    parameter int N_TAPS      = 9,
    parameter int MULT_BUDGET = 18,
    parameter int CNT_W       = 4,
    parameter int PAR_W       = 5
) (
    input  logic [CNT_W-1:0] count_i,
    output logic [PAR_W-1:0] par_o
);
    logic [PAR_W-1:0] level [N_TAPS+1];

    for (genvar n = 0; n <= N_TAPS; n++) begin : g_level
        assign level[n] = PAR_W'(pass_pixels(MULT_BUDGET, n));
    end

    assign par_o = (count_i <= CNT_W'(N_TAPS)) ? level[count_i] : '0;

endmodule

// File: rtl/mask_tap_analyzer.sv
module mask_tap_analyzer #(
    parameter int N_TAPS      = 9,
    parameter int COEF_W      = 8,
    parameter int MULT_BUDGET = 18,
    localparam int CNT_W      = $clog2(N_TAPS + 1),
    localparam int IDX_W      = $clog2(N_TAPS),
    localparam int PAR_W      = $clog2(MULT_BUDGET + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [N_TAPS*COEF_W-1:0] mask_in,
    output logic                     busy,
    output logic                     done,
    output logic [CNT_W-1:0]         distinct_cnt,
    output logic [N_TAPS*COEF_W-1:0] group_val,
    output logic [N_TAPS*N_TAPS-1:0] group_mem,
    output logic [PAR_W-1:0]         pix_par
);
    logic                     start, step, hit;
    logic [IDX_W-1:0]         idx, slot;
    logic [COEF_W-1:0]        mask_q [N_TAPS];
    logic [COEF_W-1:0]        tap_cur;

    tap_scan_ctrl #(.N_TAPS(N_TAPS), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst), .load_i(load),
        .start_o(start), .step_o(step), .idx_o(idx),
        .busy_o(busy), .done_o(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_TAPS; i++) mask_q[i] <= '0;
        end else if (start) begin
            for (int i = 0; i < N_TAPS; i++) mask_q[i] <= mask_in[i*COEF_W +: COEF_W];
        end
    end

    assign tap_cur = (idx < IDX_W'(N_TAPS)) ? mask_q[idx] : '0;

    tap_match_unit #(.N_TAPS(N_TAPS), .COEF_W(COEF_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_match (
        .clk(clk), .rst(rst), .tap_i(tap_cur), .tbl_val_i(group_val),
        .count_i(distinct_cnt), .hit_o(hit), .slot_o(slot)
    );

    tap_group_table #(.N_TAPS(N_TAPS), .COEF_W(COEF_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst), .start_i(start), .step_i(step), .done_i(done),
        .idx_i(idx), .tap_i(tap_cur), .hit_i(hit), .slot_i(slot),
        .val_o(group_val), .mem_o(group_mem), .count_o(distinct_cnt)
    );

    tap_par_select #(.N_TAPS(N_TAPS), .MULT_BUDGET(MULT_BUDGET), .CNT_W(CNT_W), .PAR_W(PAR_W)) u_par (
        .count_i(distinct_cnt), .par_o(pix_par)
    );

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        (done && !load) |=> (done && $stable(distinct_cnt) && $stable(group_val) && $stable(group_mem) && $stable(pix_par))); // R7

    AST_PAR_FITS: assert property (@(posedge clk) disable iff (rst)
        done |-> (pix_par != '0 && int'(pix_par) * int'(distinct_cnt) <= MULT_BUDGET
                  && (int'(pix_par) + 1) * int'(distinct_cnt) > MULT_BUDGET)); // R5

endmodule

// File: tb/test_mask_tap_analyzer.sv
module test_mask_tap_analyzer;
    logic        clk = 1'b0;
    logic        rst;
    logic        load;
    logic [71:0] mask_in;
    logic        busy, done;
    logic [3:0]  distinct_cnt;
    logic [71:0] group_val;
    logic [80:0] group_mem;
    logic [4:0]  pix_par;

    mask_tap_analyzer i_mask_tap_analyzer (
        .clk(clk), .rst(rst), .load(load), .mask_in(mask_in),
        .busy(busy), .done(done), .distinct_cnt(distinct_cnt),
        .group_val(group_val), .group_mem(group_mem), .pix_par(pix_par)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic signed [7:0] cur_m [9];
    logic [7:0]        exp_val [9];
    logic [8:0]        exp_mem [9];
    int                exp_cnt;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int par_of(input int n);
        case (n)
            1: return 18;
            2: return 9;
            3: return 6;
            4: return 4;
            5, 6: return 3;
            7, 8, 9: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [71:0] pack_mask();
        logic [71:0] p;
        for (int i = 0; i < 9; i++) p[i*8 +: 8] = cur_m[i];
        return p;
    endfunction

    task automatic model();
        exp_cnt = 0;
        for (int j = 0; j < 9; j++) begin
            exp_val[j] = '0;
            exp_mem[j] = '0;
        end
        for (int i = 0; i < 9; i++) begin
            int found = -1;
            for (int j = 0; j < exp_cnt; j++)
                if (found < 0 && exp_val[j] == cur_m[i]) found = j;
            if (found < 0) begin
                exp_val[exp_cnt] = cur_m[i];
                exp_mem[exp_cnt][i] = 1'b1;
                exp_cnt++;
            end else begin
                exp_mem[found][i] = 1'b1;
            end
        end
    endtask

    task automatic check_result(input string tag);
        chk(distinct_cnt == 4'(exp_cnt), "R2", {tag, " distinct count"}, distinct_cnt, exp_cnt);
        chk(int'(pix_par) == par_of(exp_cnt), "R5", {tag, " pixels per pass"}, pix_par, par_of(exp_cnt));
        for (int j = 0; j < 9; j++) begin
            chk(group_val[j*8 +: 8] == exp_val[j], "R3", $sformatf("%s entry %0d value", tag, j),
                group_val[j*8 +: 8], exp_val[j]);
            chk(group_mem[j*9 +: 9] == exp_mem[j], "R4", $sformatf("%s entry %0d positions", tag, j),
                group_mem[j*9 +: 9], exp_mem[j]);
        end
    endtask

    // Load cur_m at an edge, check R1 timing, then the tables.
    task automatic run_mask(input string tag);
        model();
        @(negedge clk);
        mask_in = pack_mask();
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R1", {tag, " busy after accept"}, {busy, done}, 2'b10);
        repeat (8) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b1, "R1", {tag, " still busy at edge k+8"}, {busy, done}, 2'b10);
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R1", {tag, " done at edge k+9"}, {busy, done}, 2'b01);
        check_result(tag);
    endtask

    task automatic set9(input int a, input int b, input int c, input int d, input int e,
                        input int f, input int g, input int h, input int k);
        cur_m[0] = 8'(a); cur_m[1] = 8'(b); cur_m[2] = 8'(c);
        cur_m[3] = 8'(d); cur_m[4] = 8'(e); cur_m[5] = 8'(f);
        cur_m[6] = 8'(g); cur_m[7] = 8'(h); cur_m[8] = 8'(k);
    endtask

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0]  held_cnt;
        logic [80:0] held_mem;
        logic [71:0] held_val;
        rst = 1'b1; load = 1'b0; mask_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(busy == 0 && done == 0, "R8", "status after reset", {busy, done}, 0);
        chk(distinct_cnt == 0 && pix_par == 0, "R8", "count and level after reset", {distinct_cnt, pix_par}, 0);
        chk(group_val == '0 && group_mem == '0, "R8", "tables after reset", group_mem, 0);

        // R2 known filter masks
        set9(7, 7, 7, 7, 7, 7, 7, 7, 7);       run_mask("smoothing");
        chk(distinct_cnt == 1, "R2", "smoothing gives 1", distinct_cnt, 1);
        set9(-1, -1, -1, -1, 8, -1, -1, -1, -1); run_mask("sharpen");
        chk(distinct_cnt == 2, "R2", "sharpen gives 2", distinct_cnt, 2);
        set9(-1, -1, -1, 0, 0, 0, 1, 1, 1);    run_mask("gradient");
        chk(distinct_cnt == 3, "R2", "gradient gives 3", distinct_cnt, 3);
        set9(-1, -2, -1, 0, 0, 0, 1, 2, 1);    run_mask("weighted gradient");
        chk(distinct_cnt == 5, "R2", "weighted gradient gives 5", distinct_cnt, 5);
        set9(-128, 127, -128, 0, 127, 0, -1, -128, 1); run_mask("extremes");

        // Sweep of exact distinct counts 1..9 (R5 full map)
        for (int k = 1; k <= 9; k++) begin
            for (int i = 0; i < 9; i++) cur_m[i] = 8'(((8 - i) % k) * 3 - 5);
            run_mask($sformatf("sweep k=%0d", k));
        end

        // Pseudo-random masks over small alphabets (R3, R4)
        for (int t = 0; t < 160; t++) begin
            for (int i = 0; i < 9; i++) begin
                lfsr = lfsr_next(lfsr);
                if (t < 80) cur_m[i] = 8'(int'(lfsr[7:0] % 5) - 2);
                else        cur_m[i] = 8'(int'(lfsr[7:0] % 11) - 5);
            end
            run_mask($sformatf("random %0d", t));
        end

        // R7: result held while mask_in wanders, no load
        held_cnt = distinct_cnt; held_mem = group_mem; held_val = group_val;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            mask_in = ~mask_in ^ {9{8'(c)}};
        end
        chk(done == 1'b1, "R7", "done held", done, 1);
        chk(distinct_cnt == held_cnt && group_mem == held_mem && group_val == held_val,
            "R7", "tables held", group_mem, held_mem);

        // R9: load while done restarts
        set9(3, 3, 3, 3, 3, 3, 3, 3, 4);
        model();
        mask_in = pack_mask();
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk(done == 1'b0 && busy == 1'b1, "R9", "restart from done", {busy, done}, 2'b10);
        // R6: strobe and new mask during scan are ignored
        repeat (3) @(negedge clk);
        mask_in = {9{8'h55}};
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk(busy == 1'b1, "R6", "still busy after ignored strobe", busy, 1);
        repeat (4) @(negedge clk);
        chk(done == 1'b0, "R6", "no restart: not done at edge k+8", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R6", "original timing kept", done, 1);
        check_result("ignored strobe");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule